// File: doc/BRIEF.md
# Address Match Trigger Comparator

This block compares a bank of debug triggers against the instruction being fetched and the memory access being issued in the same cycle. Each trigger is described by a control word and a compare address, both supplied by the trigger CSR storage. The block decodes each control word into its kind, access-type enables, privilege enables, access size and action. It then reports which triggers match the current fetch address or data access under the current privilege level and virtualization state.

The core uses the per-trigger hit vector to see which triggers matched. The single breakpoint request tells the core to raise a breakpoint exception before the access commits. The index output names the lowest-numbered trigger behind that request. Matching is exact address equality only. Decoded configuration is held in registers, so a new control word or compare address takes effect one clock after it is presented.

Top module: `atm_trigger_unit`

## Requirements
- R1: While `rst_n` is low the hit vector and the breakpoint request are zero, whatever the configuration inputs hold.
- R2: A trigger can hit only when at least one of its privilege-enable bits (bits 6:3, plus bits 24:23 for the virtualized kind) is set and at least one of load (bit 0), store (bit 1) or execute (bit 2) is set.
- R3: An execute hit needs `fetch_valid`, the execute bit, and `fetch_pc` exactly equal to the trigger's compare address; any single differing address bit prevents the hit.
- R4: A data hit needs `mem_valid`, the load bit when `mem_store` is 0 or the store bit when `mem_store` is 1, and `mem_addr` exactly equal to the compare address.
- R5: With `virt_on` low, a trigger is enabled at privilege `priv` (0 user, 1 supervisor, 3 machine) only when control bit 3+`priv` is set.
- R6: With `virt_on` high, only kind-6 triggers can hit, gated by control bit 23+`priv` (0 virtual user, 1 virtual supervisor); kind-2 triggers never hit.
- R7: The data-access size code is bits 19:16 for kind 6. For kind 2 it is bits 17:16, with bits 22:21 as the upper half when XLEN is 64. A code of 0 matches any `mem_size`; any other code matches only an equal `mem_size`. The size code does not affect execute hits.
- R8: The action field is bits 15:12. A hitting trigger sets its hit-vector bit for any action, but it contributes to `bkpt_req` only when its action is 0.
- R9: The trigger kind is the top four control bits. Only kinds 2 and 6 can hit; any other kind never hits.
- R10: `hit_vec` and `bkpt_req` follow the strobe and address inputs within the same cycle, with no register in that path.
- R11: When several triggers request a breakpoint at once, `bkpt_req` is a single bit and `bkpt_idx` is the lowest index among them. With no request, `bkpt_idx` is 0.
- R12: A change on `tcfg_ctrl` or `tcfg_addr` affects matching only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tcfg_ctrl | input | NTRIG*XLEN | Control words, trigger i in slice i |
| tcfg_addr | input | NTRIG*XLEN | Compare addresses, trigger i in slice i |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | XLEN | Fetch address |
| mem_valid | input | 1 | Data access is valid this cycle |
| mem_store | input | 1 | 1 for a store, 0 for a load |
| mem_addr | input | XLEN | Data access address |
| mem_size | input | 4 | Access size code |
| priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualization active |
| hit_vec | output | NTRIG | Per-trigger match |
| bkpt_req | output | 1 | Breakpoint exception request |
| bkpt_idx | output | IDXW | Lowest requesting trigger |

## Verification
The bench sweeps every kind, privilege-enable pattern and access-type pattern of one trigger against every privilege level, both virtualization states and all three operations. This exposes a design that uses the wrong enable bit offset, or one that lets a kind-2 trigger fire under virtualization. It flips each address bit in turn, so a comparator that ignores part of the address shows up. It also sweeps every size code against every access size, which catches a kind-2 decode that reads the kind-6 size bits. Sweeps over action codes and over all combinations of enabled triggers and action codes catch a request raised for a non-zero action, and a priority encoder that reports the highest or the last index. A one-cycle probe around a configuration change catches a design that forwards the raw CSR value straight to the comparators.

// File: rtl/atm_pkg.sv
package atm_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_AM2  = 2'd1,
        KIND_AM6  = 2'd2
    } trig_kind_e;

    // Decoded view of one trigger control word
    typedef struct packed {
        trig_kind_e kind;
        logic       armed;
        logic       en_ld;
        logic       en_st;
        logic       en_ex;
        logic [3:0] pmask;     // enable per non-virtual privilege level
        logic [1:0] vmask;     // enable per virtual privilege level
        logic [3:0] size;
        logic       act_bkpt;  // action code is zero
    } trig_dec_t;

    localparam int BIT_LD     = 0;
    localparam int BIT_ST     = 1;
    localparam int BIT_EX     = 2;
    localparam int PMODE_LSB  = 3;
    localparam int ACT_LSB    = 12;
    localparam int SIZE_LSB   = 16;
    localparam int SIZEHI_LSB = 21;
    localparam int VMODE_LSB  = 23;
    localparam logic [3:0] KIND_CODE_AM2 = 4'd2;
    localparam logic [3:0] KIND_CODE_AM6 = 4'd6;

endpackage

// File: rtl/atm_cfg_decode.sv
module atm_cfg_decode
    import atm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ctrl,
    output trig_dec_t       dec
);
    logic [3:0] kind_code;
    logic [3:0] size_am2;
    logic       mode_any;
    logic       rwx_any;

    assign kind_code = ctrl[XLEN-1 -: 4];

    generate
        if (XLEN >= 64) begin : g_wide
            assign size_am2 = {ctrl[SIZEHI_LSB +: 2], ctrl[SIZE_LSB +: 2]};
        end else begin : g_narrow
            assign size_am2 = {2'b00, ctrl[SIZE_LSB +: 2]};
        end
    endgenerate

    always_comb begin
        dec = '0;
        dec.en_ld    = ctrl[BIT_LD];
        dec.en_st    = ctrl[BIT_ST];
        dec.en_ex    = ctrl[BIT_EX];
        dec.pmask    = ctrl[PMODE_LSB +: 4];
        dec.act_bkpt = (ctrl[ACT_LSB +: 4] == 4'd0);
        unique case (kind_code)
            KIND_CODE_AM2: begin
                dec.kind = KIND_AM2;
                dec.size = size_am2;
            end
            KIND_CODE_AM6: begin
                dec.kind  = KIND_AM6;
                dec.size  = ctrl[SIZE_LSB +: 4];
                dec.vmask = ctrl[VMODE_LSB +: 2];
            end
            default: dec.kind = KIND_NONE;
        endcase
        mode_any  = (|dec.pmask) | (|dec.vmask);
        rwx_any   = dec.en_ld | dec.en_st | dec.en_ex;
        dec.armed = mode_any & rwx_any & (dec.kind != KIND_NONE);
    end
endmodule

// File: rtl/atm_match.sv
module atm_match
    import atm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  trig_dec_t       dec,
    input  logic [XLEN-1:0] cmp_addr,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            mem_valid,
    input  logic            mem_store,
    input  logic [XLEN-1:0] mem_addr,
    input  logic [3:0]      mem_size,
    input  logic [1:0]      priv,
    input  logic            virt_on,
    output logic            hit,
    output logic            req
);
    logic priv_ok;
    logic exec_hit;
    logic mem_hit;
    logic size_ok;
    logic dir_ok;

    always_comb begin
        if (virt_on) begin
            priv_ok = (dec.kind == KIND_AM6) && !priv[1] && dec.vmask[priv[0]];
        end else begin
            priv_ok = dec.pmask[priv];
        end
        size_ok  = (dec.size == 4'd0) || (dec.size == mem_size);
        dir_ok   = mem_store ? dec.en_st : dec.en_ld;
        exec_hit = fetch_valid && dec.en_ex && (fetch_pc == cmp_addr);
        mem_hit  = mem_valid && dir_ok && size_ok && (mem_addr == cmp_addr);
        hit      = dec.armed && priv_ok && (exec_hit || mem_hit);
        req      = hit && dec.act_bkpt;
    end
endmodule

// File: rtl/atm_prio.sv
module atm_prio #(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input  logic [N-1:0]    req_vec,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = |req_vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/atm_trigger_unit.sv
module atm_trigger_unit
    import atm_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int XLEN  = 32,
    localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTRIG*XLEN-1:0] tcfg_ctrl,
    input  logic [NTRIG*XLEN-1:0] tcfg_addr,
    input  logic                  fetch_valid,
    input  logic [XLEN-1:0]       fetch_pc,
    input  logic                  mem_valid,
    input  logic                  mem_store,
    input  logic [XLEN-1:0]       mem_addr,
    input  logic [3:0]            mem_size,
    input  logic [1:0]            priv,
    input  logic                  virt_on,
    output logic [NTRIG-1:0]      hit_vec,
    output logic                  bkpt_req,
    output logic [IDXW-1:0]       bkpt_idx
);
    typedef struct packed {
        trig_dec_t [NTRIG-1:0]            dec;
        logic      [NTRIG-1:0][XLEN-1:0]  addr;
    } cfg_state_t;

    cfg_state_t            st_d, st_q;
    trig_dec_t [NTRIG-1:0] dec_raw;
    logic      [NTRIG-1:0] req_vec;

    genvar g;
    generate
        for (g = 0; g < NTRIG; g++) begin : g_trig
            atm_cfg_decode #(.XLEN(XLEN)) u_dec (
                .ctrl (tcfg_ctrl[g*XLEN +: XLEN]),
                .dec  (dec_raw[g])
            );

            atm_match #(.XLEN(XLEN)) u_match (
                .dec         (st_q.dec[g]),
                .cmp_addr    (st_q.addr[g]),
                .fetch_valid (fetch_valid),
                .fetch_pc    (fetch_pc),
                .mem_valid   (mem_valid),
                .mem_store   (mem_store),
                .mem_addr    (mem_addr),
                .mem_size    (mem_size),
                .priv        (priv),
                .virt_on     (virt_on),
                .hit         (hit_vec[g]),
                .req         (req_vec[g])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NTRIG; i++) begin
            st_d.dec[i]  = dec_raw[i];
            st_d.addr[i] = tcfg_addr[i*XLEN +: XLEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    atm_prio #(.N(NTRIG), .IDXW(IDXW)) u_prio (
        .req_vec (req_vec),
        .any     (bkpt_req),
        .idx     (bkpt_idx)
    );
endmodule

// File: rtl/atm_trigger_unit_chk.sv
module atm_trigger_unit_chk #(
    parameter int NTRIG = 4,
    parameter int IDXW  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             mem_valid,
    input logic [NTRIG-1:0] hit_vec,
    input logic             bkpt_req,
    input logic [IDXW-1:0]  bkpt_idx
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (hit_vec == '0 && !bkpt_req));

    // R3
    no_strobe_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !mem_valid) |-> (hit_vec == '0));

    // R8
    req_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |-> (hit_vec != '0));

    // R11
    idx_points_at_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_req |-> hit_vec[bkpt_idx]);

    // R11
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bkpt_req |-> (bkpt_idx == '0));
endmodule

bind atm_trigger_unit atm_trigger_unit_chk #(.NTRIG(NTRIG), .IDXW(IDXW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .mem_valid   (mem_valid),
    .hit_vec     (hit_vec),
    .bkpt_req    (bkpt_req),
    .bkpt_idx    (bkpt_idx)
);

// File: tb/atm_trigger_unit_tb.sv
module atm_trigger_unit_tb;
    localparam int NT = 4;
    localparam int XL = 32;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT*XL-1:0]  tcfg_ctrl = '0;
    logic [NT*XL-1:0]  tcfg_addr = '0;
    logic              fetch_valid = 1'b0;
    logic [XL-1:0]     fetch_pc = '0;
    logic              mem_valid = 1'b0;
    logic              mem_store = 1'b0;
    logic [XL-1:0]     mem_addr = '0;
    logic [3:0]        mem_size = '0;
    logic [1:0]        priv = '0;
    logic              virt_on = 1'b0;
    logic [NT-1:0]     hit_vec;
    logic              bkpt_req;
    logic [IW-1:0]     bkpt_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    atm_trigger_unit #(.NTRIG(NT), .XLEN(XL)) u_dut (
        .clk(clk), .rst_n(rst_n), .tcfg_ctrl(tcfg_ctrl), .tcfg_addr(tcfg_addr),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .mem_valid(mem_valid),
        .mem_store(mem_store), .mem_addr(mem_addr), .mem_size(mem_size),
        .priv(priv), .virt_on(virt_on), .hit_vec(hit_vec), .bkpt_req(bkpt_req),
        .bkpt_idx(bkpt_idx)
    );

    function automatic logic [XL-1:0] mkc(input logic [3:0] ty, input logic [1:0] vm,
                                         input logic [3:0] pm, input logic [3:0] sz,
                                         input logic [3:0] act, input logic [2:0] rwx);
        return (XL'(ty) << 28) | (XL'(vm) << 23) | (XL'(sz) << 16) |
               (XL'(act) << 12) | (XL'(pm) << 3) | XL'(rwx);
    endfunction

    // Expected hit from the requirement text
    function automatic bit ref_hit(input logic [XL-1:0] c, input logic [XL-1:0] a,
                                   input bit fv, input logic [XL-1:0] pc, input bit mv,
                                   input bit ms, input logic [XL-1:0] ma, input logic [3:0] msz,
                                   input logic [1:0] pr, input bit vt);
        logic [3:0] ty = c[31:28];
        bit is6 = (ty == 4'd6);
        bit is2 = (ty == 4'd2);
        logic [3:0] sz = is6 ? c[19:16] : {2'b00, c[17:16]};
        bit modes = (c[6:3] != 0) || (is6 && c[24:23] != 0);
        bit rwx = (c[2:0] != 0);
        bit pok;
        bit ex, mm;
        if (!(is2 || is6) || !modes || !rwx) return 1'b0;
        if (vt) pok = is6 && (pr < 2) && c[23 + pr];
        else    pok = c[3 + pr];
        ex = fv && c[2] && (pc == a);
        mm = mv && (ms ? c[1] : c[0]) && (ma == a) && (sz == 0 || sz == msz);
        return pok && (ex || mm);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_cfg;
        @(negedge clk);
    endtask

    task automatic commit;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        fetch_valid = 0; mem_valid = 0; mem_store = 0; mem_size = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [XL-1:0] c;
        logic [XL-1:0] base;
        base = 32'h8000_1230;

        // R1: reset holds outputs low with a live config
        tcfg_ctrl[0 +: XL] = mkc(4'd2, 2'd0, 4'hF, 4'd0, 4'd0, 3'b111);
        tcfg_addr[0 +: XL] = base;
        fetch_valid = 1; fetch_pc = base;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 hit_vec in reset", 32'(hit_vec), 0);
        chk("R1 bkpt_req in reset", 32'(bkpt_req), 0);
        @(negedge clk);
        rst_n = 1;
        idle();

        // R2 R3 R4 R5 R6 R9: kind x modes x access types x priv x virt x op
        for (int t = 0; t < 3; t++) begin
            for (int pm = 0; pm < 16; pm++) begin
                for (int vm = 0; vm < 4; vm++) begin
                    for (int rwx = 0; rwx < 8; rwx++) begin
                        logic [3:0] ty;
                        ty = (t == 0) ? 4'd2 : (t == 1) ? 4'd6 : 4'd5;
                        c = mkc(ty, vm[1:0], pm[3:0], 4'd0, 4'd0, rwx[2:0]);
                        load_cfg();
                        idle();
                        tcfg_ctrl = '0;
                        tcfg_ctrl[0 +: XL] = c;
                        tcfg_addr[0 +: XL] = base;
                        commit();
                        for (int pr = 0; pr < 4; pr++) begin
                            for (int vt = 0; vt < 2; vt++) begin
                                for (int op = 0; op < 3; op++) begin
                                    bit e;
                                    priv = pr[1:0]; virt_on = vt[0];
                                    fetch_valid = (op == 0); fetch_pc = base;
                                    mem_valid = (op != 0); mem_store = (op == 2);
                                    mem_addr = base; mem_size = 4'd3;
                                    #1;
                                    e = ref_hit(c, base, fetch_valid, base, mem_valid,
                                                mem_store, base, 4'd3, pr[1:0], vt[0]);
                                    chk("R2/R3/R4/R5/R6/R9 hit", 32'(hit_vec), 32'(e));
                                    chk("R2/R5/R6/R9 req", 32'(bkpt_req), 32'(e));
                                end
                            end
                        end
                    end
                end
            end
        end
        virt_on = 0; priv = 2'd3; idle();

        // R3 R4: any single differing address bit blocks the match
        load_cfg();
        tcfg_ctrl = '0;
        tcfg_ctrl[0 +: XL] = mkc(4'd6, 2'd0, 4'b1000, 4'd0, 4'd0, 3'b111);
        commit();
        for (int b = 0; b < XL; b++) begin
            fetch_valid = 1; fetch_pc = base ^ (32'd1 << b); mem_valid = 0;
            #1;
            chk("R3 exec addr bit flip", 32'(hit_vec), 0);
            fetch_valid = 0; mem_valid = 1; mem_store = b[0]; mem_addr = base ^ (32'd1 << b);
            #1;
            chk("R4 data addr bit flip", 32'(hit_vec), 0);
            mem_addr = base;
            #1;
            chk("R4 data addr exact", 32'(hit_vec), 1);
        end
        idle();

        // R7: size code against access size, both kinds
        for (int k = 0; k < 2; k++) begin
            for (int sz = 0; sz < 16; sz++) begin
                c = mkc(k == 0 ? 4'd2 : 4'd6, 2'd0, 4'b1000, sz[3:0], 4'd0, 3'b011);
                load_cfg();
                idle();
                tcfg_ctrl[0 +: XL] = c;
                commit();
                for (int ms = 0; ms < 16; ms++) begin
                    bit e;
                    logic [3:0] eff;
                    eff = (k == 0) ? {2'b00, sz[1:0]} : sz[3:0];
                    e = (eff == 0) || (eff == ms[3:0]);
                    mem_valid = 1; mem_store = ms[0]; mem_addr = base; mem_size = ms[3:0];
                    #1;
                    chk("R7 size match", 32'(hit_vec), 32'(e));
                end
                mem_valid = 0; fetch_valid = 1; fetch_pc = base;
                c[2] = 1'b1;
                load_cfg();
                tcfg_ctrl[0 +: XL] = c;
                commit();
                mem_size = 4'd7;
                #1;
                chk("R7 size ignored for execute", 32'(hit_vec), 1);
                idle();
            end
        end

        // R8: action code gating
        for (int a = 0; a < 16; a++) begin
            load_cfg();
            idle();
            tcfg_ctrl[0 +: XL] = mkc(4'd6, 2'd0, 4'b1000, 4'd0, a[3:0], 3'b100);
            commit();
            fetch_valid = 1; fetch_pc = base;
            #1;
            chk("R8 hit for any action", 32'(hit_vec), 1);
            chk("R8 request only for action 0", 32'(bkpt_req), 32'(a == 0));
        end
        idle();

        // R11: several triggers, enable subsets x action subsets
        for (int en = 0; en < 16; en++) begin
            for (int am = 0; am < 16; am++) begin
                logic [3:0] rq;
                int lo;
                load_cfg();
                idle();
                for (int i = 0; i < NT; i++) begin
                    tcfg_ctrl[i*XL +: XL] = mkc(4'd2, 2'd0, en[i] ? 4'b1000 : 4'b0000,
                                                4'd0, am[i] ? 4'd1 : 4'd0, 3'b100);
                    tcfg_addr[i*XL +: XL] = base;
                end
                commit();
                fetch_valid = 1; fetch_pc = base;
                #1;
                rq = en[3:0] & ~am[3:0];
                lo = 0;
                for (int i = NT - 1; i >= 0; i--) if (rq[i]) lo = i;
                chk("R11 hit vector", 32'(hit_vec), 32'(en[3:0]));
                chk("R11 single request", 32'(bkpt_req), 32'(rq != 0));
                chk("R11 lowest index", 32'(bkpt_idx), 32'(lo));
            end
        end

        // R10: output follows the strobe inside the cycle
        load_cfg();
        idle();
        tcfg_ctrl = '0;
        tcfg_ctrl[2*XL +: XL] = mkc(4'd2, 2'd0, 4'b1000, 4'd0, 4'd0, 3'b100);
        tcfg_addr[2*XL +: XL] = base;
        commit();
        fetch_valid = 1; fetch_pc = base;
        #0.5;
        chk("R10 same-cycle request", 32'(bkpt_req), 1);
        chk("R10 same-cycle index", 32'(bkpt_idx), 2);
        fetch_valid = 0;
        #0.5;
        chk("R10 same-cycle drop", 32'(bkpt_req), 0);

        // R12: configuration change waits for a clock edge
        fetch_valid = 1;
        @(negedge clk);
        tcfg_ctrl[2*XL +: XL] = '0;
        tcfg_addr[0 +: XL] = base;
        tcfg_ctrl[0 +: XL] = mkc(4'd2, 2'd0, 4'b1000, 4'd0, 4'd0, 3'b100);
        #1;
        chk("R12 old config before edge", 32'(hit_vec), 32'h4);
        commit();
        chk("R12 new config after edge", 32'(hit_vec), 32'h1);
        chk("R12 new index after edge", 32'(bkpt_idx), 0);
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule